// File: doc/BRIEF.md
# Suffix-State Walker for Two-Stage Signature Matching

This block is the back half of a two-stage payload signature matcher. A front stage hashes short literal prefixes. On each hit it pushes a partial-match record into a queue. The record holds a rule identifier, the automaton state to enter and the payload offset of the first byte after the prefix. The walker drains that queue one record at a time while the front stage keeps scanning.

For each record the walker follows a single shared deterministic automaton held in a table RAM, reading payload bytes from a separate byte-wide memory. Rules whose tails look alike can enter the same chain of states at different depths, so they share table storage. A walk ends in one of three ways: it reaches an accepting state and emits a one-cycle report, it falls into the dead state, or it runs off the end of the packet. In the last two cases the record is dropped silently.

Each state occupies one property word followed by one next-state word per character code. Both memories are read with one cycle of latency.

Top module: `dfa_walk_engine`

## Requirements
- R1: While reset is high and on the first cycle after it, `q_pop`, `m_valid`, `pay_rd` and `tbl_rd` are all low.
- R2: `q_pop` is a single-cycle pulse issued only while `q_valid` is high. Exactly one record is taken per walk, and the next record is not taken until the current walk has ended.
- R3: The table word address of the property word of state s is s·(2^CHAR_W+1). The next-state word for state s and byte b is at s·(2^CHAR_W+1)+1+b[CHAR_W-1:0]. CHAR_W is 7 or 8, and all 8 bits of a byte select the entry when CHAR_W is 8.
- R4: Only bit 0 of a property word decides acceptance (1 = accepting). The other 15 bits are ignored.
- R5: A walk starts in the record's entry state and reads bytes from the record's offset upward. Records that share an entry state are walked independently. The report carries the record's rule identifier.
- R6: On reaching an accepting state the block raises `m_valid` for exactly one cycle. It reports `m_start` = record offset and `m_end` = offset just past the last byte consumed. An accepting entry state gives `m_end` = `m_start`.
- R7: State 0 is dead. A walk that is in state 0 ends with no report, and the table word at address 0 is never read.
- R8: A walk that has consumed all bytes up to `pkt_end` without being accepted ends with no report. No payload read is issued at an address ≥ `pkt_end`. Acceptance is tested before the end of the packet, so a pattern that completes on the last byte is reported.
- R9: Each consumed byte costs three cycles. `m_valid` rises 3·(`m_end`−`m_start`)+2 cycles after the rising edge of `q_pop` for that record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| q_valid | input | 1 | Queue holds at least one record |
| q_rule | input | RULE_W | Rule identifier of the head record |
| q_state | input | STATE_W | Entry state of the head record |
| q_pos | input | POS_W | Payload offset after the matched prefix |
| pkt_end | input | POS_W | Payload length (first offset outside the packet) |
| q_pop | output | 1 | Removes the head record |
| pay_rd | output | 1 | Payload read strobe |
| pay_addr | output | POS_W | Payload byte offset |
| pay_data | input | 8 | Payload byte, one cycle after the strobe |
| tbl_rd | output | 1 | Table read strobe |
| tbl_addr | output | STATE_W+CHAR_W+1 | Table word address |
| tbl_data | input | STATE_W | Table word, one cycle after the strobe |
| m_valid | output | 1 | Match report strobe |
| m_rule | output | RULE_W | Matched rule identifier |
| m_start | output | POS_W | Offset where the walk began |
| m_end | output | POS_W | Offset just past the last consumed byte |

## Verification
The assertions rely on four conditions:
- Both memories return data exactly one cycle after a strobe.
- `pkt_end` stays fixed while records are queued or a walk is running.
- Every queued offset lies between 0 and `pkt_end`.
- Every table word names a valid state.

The bench changes the payload, the packet length and the table contents only after the queue is empty and a full worst-case walk time has elapsed. It draws every random offset in the range 0 to `pkt_end` and answers every table address from a generator that produces only in-range states.

// File: rtl/dfa_walk_pkg.sv
package dfa_walk_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ISSUE = 2'd1,
    PH_EVAL  = 2'd2,
    PH_STEP  = 2'd3
  } walk_phase_t;

  localparam int ACCEPT_BIT = 0;

endpackage

// File: rtl/dfa_tbl_addr.sv
module dfa_tbl_addr #(
  parameter int STATE_W = 16,
  parameter int CHAR_W  = 8,
  parameter int ADDR_W  = STATE_W + CHAR_W + 1
) (
  input  logic [STATE_W-1:0] state_i,
  input  logic [7:0]         byte_i,
  output logic [ADDR_W-1:0]  prop_addr_o,
  output logic [ADDR_W-1:0]  next_addr_o
);

  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] code;

  // state * (2^CHAR_W + 1) as a shift plus one add
  assign base = (ADDR_W'(state_i) << CHAR_W) + ADDR_W'(state_i);

  generate
    if (CHAR_W >= 8) begin : g_full_byte
      assign code = ADDR_W'(byte_i);
    end else begin : g_narrow
      assign code = ADDR_W'(byte_i[CHAR_W-1:0]);
    end
  endgenerate

  assign prop_addr_o = base;
  assign next_addr_o = base + ADDR_W'(1) + code;

endmodule

// File: rtl/dfa_step_fsm.sv
module dfa_step_fsm
  import dfa_walk_pkg::*;
#(
  parameter int RULE_W  = 8,
  parameter int STATE_W = 16,
  parameter int POS_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               q_valid,
  input  logic [RULE_W-1:0]  q_rule,
  input  logic [STATE_W-1:0] q_state,
  input  logic [POS_W-1:0]   q_pos,
  input  logic [POS_W-1:0]   pkt_end,
  output logic               q_pop,
  output logic               pay_rd,
  output logic [POS_W-1:0]   pay_addr,
  output logic               tbl_rd,
  output logic               sel_next,
  input  logic [STATE_W-1:0] tbl_data,
  output logic [STATE_W-1:0] cur_state_o,
  output logic               hit,
  output logic [RULE_W-1:0]  hit_rule,
  output logic [POS_W-1:0]   hit_start,
  output logic [POS_W-1:0]   hit_end
);

  walk_phase_t        phase;
  logic               pop_r;
  logic [RULE_W-1:0]  rule_r;
  logic [STATE_W-1:0] cur_state;
  logic [POS_W-1:0]   start_r;
  logic [POS_W-1:0]   cur_pos;
  logic               at_end;
  logic               is_dead;
  logic               accepting;

  assign at_end    = (cur_pos >= pkt_end);
  assign is_dead   = (cur_state == '0);
  assign accepting = tbl_data[ACCEPT_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      pop_r     <= 1'b0;
      rule_r    <= '0;
      cur_state <= '0;
      start_r   <= '0;
      cur_pos   <= '0;
    end else begin
      pop_r <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (q_valid) begin
            pop_r     <= 1'b1;
            rule_r    <= q_rule;
            cur_state <= q_state;
            start_r   <= q_pos;
            cur_pos   <= q_pos;
            phase     <= PH_ISSUE;
          end
        end
        PH_ISSUE: begin
          phase <= is_dead ? PH_IDLE : PH_EVAL;
        end
        PH_EVAL: begin
          if (accepting || at_end) begin
            phase <= PH_IDLE;
          end else begin
            cur_pos <= cur_pos + POS_W'(1);
            phase   <= PH_STEP;
          end
        end
        PH_STEP: begin
          cur_state <= tbl_data;
          phase     <= PH_ISSUE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    pay_rd   = (phase == PH_ISSUE) && !is_dead && !at_end;
    tbl_rd   = ((phase == PH_ISSUE) && !is_dead) ||
               ((phase == PH_EVAL) && !accepting && !at_end);
    sel_next = (phase == PH_EVAL);
    hit      = (phase == PH_EVAL) && accepting;
  end

  assign q_pop       = pop_r;
  assign pay_addr    = cur_pos;
  assign cur_state_o = cur_state;
  assign hit_rule    = rule_r;
  assign hit_start   = start_r;
  assign hit_end     = cur_pos;

  // R2: a pop is a single pulse and only follows a non-empty queue
  p_pop_once_r2: assert property (@(posedge clk) disable iff (rst)
    q_pop |=> !q_pop);
  p_pop_valid_r2: assert property (@(posedge clk) disable iff (rst)
    q_pop |-> $past(q_valid));

  // R8: payload reads stay inside the packet
  p_pay_bound_r8: assert property (@(posedge clk) disable iff (rst)
    pay_rd |-> (pay_addr < pkt_end));

  // R6: a hit lies between the record offset and the packet end
  p_hit_bound_r6: assert property (@(posedge clk) disable iff (rst)
    hit |-> ((hit_end >= hit_start) && (hit_end <= pkt_end)));

endmodule

// File: rtl/dfa_match_reg.sv
module dfa_match_reg #(
  parameter int RULE_W = 8,
  parameter int POS_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit,
  input  logic [RULE_W-1:0] hit_rule,
  input  logic [POS_W-1:0]  hit_start,
  input  logic [POS_W-1:0]  hit_end,
  output logic              m_valid,
  output logic [RULE_W-1:0] m_rule,
  output logic [POS_W-1:0]  m_start,
  output logic [POS_W-1:0]  m_end
);

  always_ff @(posedge clk) begin
    if (rst) begin
      m_valid <= 1'b0;
      m_rule  <= '0;
      m_start <= '0;
      m_end   <= '0;
    end else begin
      m_valid <= hit;
      if (hit) begin
        m_rule  <= hit_rule;
        m_start <= hit_start;
        m_end   <= hit_end;
      end
    end
  end

  // R6: each report lasts one cycle and never ends before it starts
  p_report_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    m_valid |=> !m_valid);
  p_report_order_r6: assert property (@(posedge clk) disable iff (rst)
    m_valid |-> (m_end >= m_start));

endmodule

// File: rtl/dfa_walk_engine.sv
module dfa_walk_engine #(
  parameter int RULE_W  = 8,
  parameter int STATE_W = 16,
  parameter int POS_W   = 16,
  parameter int CHAR_W  = 8,
  localparam int ADDR_W = STATE_W + CHAR_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               q_valid,
  input  logic [RULE_W-1:0]  q_rule,
  input  logic [STATE_W-1:0] q_state,
  input  logic [POS_W-1:0]   q_pos,
  input  logic [POS_W-1:0]   pkt_end,
  output logic               q_pop,
  output logic               pay_rd,
  output logic [POS_W-1:0]   pay_addr,
  input  logic [7:0]         pay_data,
  output logic               tbl_rd,
  output logic [ADDR_W-1:0]  tbl_addr,
  input  logic [STATE_W-1:0] tbl_data,
  output logic               m_valid,
  output logic [RULE_W-1:0]  m_rule,
  output logic [POS_W-1:0]   m_start,
  output logic [POS_W-1:0]   m_end
);

  logic               sel_next;
  logic [STATE_W-1:0] cur_state;
  logic [ADDR_W-1:0]  prop_addr;
  logic [ADDR_W-1:0]  next_addr;
  logic               hit;
  logic [RULE_W-1:0]  hit_rule;
  logic [POS_W-1:0]   hit_start;
  logic [POS_W-1:0]   hit_end;

  dfa_step_fsm #(
    .RULE_W (RULE_W),
    .STATE_W(STATE_W),
    .POS_W  (POS_W)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .q_valid    (q_valid),
    .q_rule     (q_rule),
    .q_state    (q_state),
    .q_pos      (q_pos),
    .pkt_end    (pkt_end),
    .q_pop      (q_pop),
    .pay_rd     (pay_rd),
    .pay_addr   (pay_addr),
    .tbl_rd     (tbl_rd),
    .sel_next   (sel_next),
    .tbl_data   (tbl_data),
    .cur_state_o(cur_state),
    .hit        (hit),
    .hit_rule   (hit_rule),
    .hit_start  (hit_start),
    .hit_end    (hit_end)
  );

  dfa_tbl_addr #(
    .STATE_W(STATE_W),
    .CHAR_W (CHAR_W),
    .ADDR_W (ADDR_W)
  ) u_addr (
    .state_i    (cur_state),
    .byte_i     (pay_data),
    .prop_addr_o(prop_addr),
    .next_addr_o(next_addr)
  );

  assign tbl_addr = sel_next ? next_addr : prop_addr;

  dfa_match_reg #(
    .RULE_W(RULE_W),
    .POS_W (POS_W)
  ) u_report (
    .clk      (clk),
    .rst      (rst),
    .hit      (hit),
    .hit_rule (hit_rule),
    .hit_start(hit_start),
    .hit_end  (hit_end),
    .m_valid  (m_valid),
    .m_rule   (m_rule),
    .m_start  (m_start),
    .m_end    (m_end)
  );

  // R7: the dead state's property word (address 0) is never fetched
  p_dead_skip_r7: assert property (@(posedge clk) disable iff (rst)
    tbl_rd |-> (tbl_addr != '0));

endmodule

// File: tb/dfa_walk_engine_tb.sv
module dfa_walk_engine_tb;

  localparam int RULE_W  = 8;
  localparam int STATE_W = 16;
  localparam int POS_W   = 16;
  localparam int CHAR_W  = 8;
  localparam int ADDR_W  = STATE_W + CHAR_W + 1;
  localparam int C1      = (1 << CHAR_W) + 1;
  localparam int ACC     = 13;   // accepting state; chain is states 1..12
  localparam int NREC    = 512;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               q_valid;
  logic [RULE_W-1:0]  q_rule;
  logic [STATE_W-1:0] q_state;
  logic [POS_W-1:0]   q_pos;
  logic [POS_W-1:0]   pkt_end = '0;
  logic               q_pop;
  logic               pay_rd;
  logic [POS_W-1:0]   pay_addr;
  logic [7:0]         pay_q = '0;
  logic               tbl_rd;
  logic [ADDR_W-1:0]  tbl_addr;
  logic [STATE_W-1:0] tbl_q = '0;
  logic               m_valid;
  logic [RULE_W-1:0]  m_rule;
  logic [POS_W-1:0]   m_start;
  logic [POS_W-1:0]   m_end;

  always #10 clk = ~clk;

  logic [7:0] pay_mem [0:63];
  int rec_rule  [0:NREC-1];
  int rec_state [0:NREC-1];
  int rec_pos   [0:NREC-1];
  int exp_rule  [0:NREC-1];
  int exp_start [0:NREC-1];
  int exp_end   [0:NREC-1];
  int q_idx = 0, q_count = 0, exp_n = 0, got_n = 0;
  int cyc = 0, pop_cyc = 0;
  int total = 0, bad = 0;

  assign q_valid = (q_idx < q_count);
  assign q_rule  = RULE_W'(rec_rule[q_idx % NREC]);
  assign q_state = STATE_W'(rec_state[q_idx % NREC]);
  assign q_pos   = POS_W'(rec_pos[q_idx % NREC]);

  dfa_walk_engine #(
    .RULE_W(RULE_W), .STATE_W(STATE_W), .POS_W(POS_W), .CHAR_W(CHAR_W)
  ) u_dut (
    .clk(clk), .rst(rst), .q_valid(q_valid), .q_rule(q_rule),
    .q_state(q_state), .q_pos(q_pos), .pkt_end(pkt_end), .q_pop(q_pop),
    .pay_rd(pay_rd), .pay_addr(pay_addr), .pay_data(pay_q),
    .tbl_rd(tbl_rd), .tbl_addr(tbl_addr), .tbl_data(tbl_q),
    .m_valid(m_valid), .m_rule(m_rule), .m_start(m_start), .m_end(m_end)
  );

  // chain automaton: non-newline advances, newline (0x0A) kills
  function automatic int ref_next(input int s, input int ch);
    if (s == 0 || s >= ACC) return 0;
    if (ch == 8'h0A) return 0;
    return s + 1;
  endfunction

  function automatic logic [STATE_W-1:0] tbl_word(input logic [ADDR_W-1:0] a);
    int st, off;
    st  = int'(a) / C1;
    off = int'(a) % C1;
    if (off == 0) return (st == ACC) ? 16'h0001 : 16'hFFFE;  // R4 only bit 0
    return STATE_W'(ref_next(st, off - 1));
  endfunction

  function automatic logic ref_walk(input int e, input int p, input int lim, output int fin);
    int s, i;
    s = e; i = p; fin = 0;
    for (int k = 0; k < 80; k++) begin
      if (s == 0) return 1'b0;
      if (s == ACC) begin fin = i; return 1'b1; end
      if (i >= lim) return 1'b0;
      s = ref_next(s, int'(pay_mem[i]));
      i++;
    end
    return 1'b0;
  endfunction

  task automatic chk(input logic ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // memory and queue models, one cycle read latency
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (pay_rd) pay_q <= pay_mem[pay_addr[5:0]];
    if (tbl_rd) tbl_q <= tbl_word(tbl_addr);
    if (q_pop)  q_idx <= q_idx + 1;
  end

  always @(negedge clk) begin
    if (!rst && q_pop) begin
      pop_cyc = cyc;
      chk(q_idx < q_count, "R2", "pop with empty queue", q_idx, q_count);
    end
    if (!rst && m_valid) begin
      if (got_n >= exp_n) begin
        chk(1'b0, "R6", "unexpected report start", int'(m_start), -1);
      end else begin
        chk(int'(m_rule) == exp_rule[got_n], "R5", "rule id", int'(m_rule), exp_rule[got_n]);
        chk(int'(m_start) == exp_start[got_n], "R6", "start", int'(m_start), exp_start[got_n]);
        chk(int'(m_end) == exp_end[got_n], "R6", "end", int'(m_end), exp_end[got_n]);
        chk(cyc - pop_cyc == 3 * (int'(m_end) - int'(m_start)) + 2, "R9", "latency",
            cyc - pop_cyc, 3 * (int'(m_end) - int'(m_start)) + 2);
      end
      got_n++;
    end
  end

  task automatic add_rec(input int rule, input int entry, input int pos);
    int fin;
    rec_rule[q_count % NREC]  = rule;
    rec_state[q_count % NREC] = entry;
    rec_pos[q_count % NREC]   = pos;
    if (ref_walk(entry, pos, int'(pkt_end), fin)) begin
      exp_rule[exp_n]  = rule;
      exp_start[exp_n] = pos;
      exp_end[exp_n]   = fin;
      exp_n++;
    end
    q_count++;
  endtask

  task automatic drain(input string tag);
    while (q_idx < q_count) @(negedge clk);
    repeat (3 * 66 + 8) @(negedge clk);
    chk(got_n == exp_n, tag, "report count", got_n, exp_n);
  endtask

  task automatic fill(input logic [7:0] b);
    for (int i = 0; i < 64; i++) pay_mem[i] = b;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20517));
    fill(8'h61);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(!q_pop && !m_valid && !pay_rd && !tbl_rd, "R1", "outputs in reset",
        {q_pop, m_valid, pay_rd, tbl_rd}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!q_pop && !m_valid && !pay_rd && !tbl_rd, "R1", "outputs after reset",
        {q_pop, m_valid, pay_rd, tbl_rd}, 0);

    // R5 R6 R7: full chain, accepting entry, shared entry state, dead entry
    pkt_end = 16'd40;
    add_rec(1, 1, 0);
    add_rec(2, ACC, 5);
    add_rec(3, 7, 3);
    add_rec(4, 7, 20);
    add_rec(5, 0, 2);
    drain("R5");

    // R7: newline drives the walk to the dead state
    fill(8'h61);
    pay_mem[6] = 8'h0A;
    add_rec(6, 1, 0);
    add_rec(7, 1, 7);
    drain("R7");

    // R8: packet end before, exactly at and at the walk start
    fill(8'h62);
    pkt_end = 16'd10;
    add_rec(8, 1, 0);
    add_rec(9, 4, 0);
    add_rec(10, 3, 0);
    add_rec(11, 1, 10);
    drain("R8");

    // R3: byte 0x8A indexes its own entry and is not a newline
    fill(8'h8A);
    pkt_end = 16'd30;
    add_rec(12, 1, 0);
    add_rec(13, 9, 17);
    drain("R3");

    for (int b = 0; b < 36; b++) begin
      int n;
      pkt_end = POS_W'($urandom_range(64, 1));
      for (int i = 0; i < 64; i++) begin
        int r;
        r = $urandom_range(39, 0);
        pay_mem[i] = (r == 0) ? 8'h0A : (r == 1) ? 8'h8A : 8'($urandom);
      end
      n = $urandom_range(6, 1);
      for (int k = 0; k < n; k++) begin
        int e;
        e = ($urandom_range(7, 0) == 0) ? 0 : $urandom_range(ACC, 1);
        add_rec($urandom_range(255, 0), e, $urandom_range(int'(pkt_end), 0));
      end
      drain("R4");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule